// File: doc/BRIEF.md
# Dual-Pixel Row Readout Sequencer

This block runs the readout of one sensor row. The column logic addresses two pixels at once: one from an even column and one from an odd column. The two pixels arrive on separate buses. The block steps through these pairs on an internal tick that runs at half the system clock rate. It merges each pair into one output stream that carries one pixel per system clock.

A one-cycle row-sync pulse starts a row. From the next cycle on, the block raises its valid flag. It then emits the even-column pixel followed by the odd-column pixel of each pair. When the pair counter reaches the programmed count, the block marks the last output pixel with an end-of-line pulse and lowers valid.

The output stream has no ready input, because a sensor row cannot be paused. The downstream stage must accept a pixel in every cycle in which valid is high.

Top module: `dual_pixel_rowout`

## Requirements
- R1: When `row_sync` is sampled high at a clock edge, `pix_valid` is high in the following cycle. In that cycle `pix_data` carries the `even_data` value sampled at that same edge.
- R2: A pair's `even_data` and `odd_data` are both sampled at the edge that opens the pair. That edge is either the sync edge or the edge right after the previous pair's odd output. The even value is output in the first cycle of the pair and the odd value in the second.
- R3: A row that no sync interrupts holds `pix_valid` high for exactly 2*(N+1) consecutive cycles. N is the `pix_count` value sampled at the sync edge.
- R4: `end_of_line` is high for exactly one cycle: the cycle of the last pixel of the row, which is the odd pixel of pair N.
- R5: If no sync arrives at the edge that ends the last pixel, `pix_valid` is low in the cycle after the last pixel.
- R6: A sync that arrives while a row is active restarts the row from pair 0, with the newly sampled `pix_count`. This includes a sync on the edge that ends the last pixel.
- R7: While no row is active, `pix_data` is zero and `end_of_line` is low.
- R8: While reset is held low, `pix_valid`, `end_of_line` and `pix_data` are all zero in the cycle after the reset edge.
- R9: Changes on `pix_count` after the sync edge have no effect on the length of the current row.
- R10: The pair counter advances once every two system clocks, so a new pair is sampled at every second edge of an active row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| row_sync | input | 1 | One-cycle pulse that starts or restarts a row |
| pix_count | input | CNT_W | Index of the last pair in the row (N) |
| even_data | input | DATA_W | Even-column pixel bus |
| odd_data | input | DATA_W | Odd-column pixel bus |
| pix_data | output | DATA_W | Merged pixel stream, one pixel per clock |
| pix_valid | output | 1 | High while a row's pixels are being output |
| end_of_line | output | 1 | High on the last pixel of a row |

## Verification
The properties assume that `row_sync` is a clean synchronous pulse and that reset is synchronous. Under those assumptions, valid and end-of-line follow from the sync input alone. The stimulus drives all inputs on the falling clock edge only. It places syncs at idle, at mid-row, at mid-pair and exactly on the last-pixel edge. It changes `pix_count` after a sync to show that the row length is already fixed. The pixel buses carry fresh random values on every cycle, so sampling at the wrong edge is visible in the data.

// File: rtl/rowout_pkg.sv
package rowout_pkg;
  // half-rate tick phase: which member of the current pair is on the output
  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  function automatic phase_e next_phase(input phase_e cur);
    return (cur == PH_EVEN) ? PH_ODD : PH_EVEN;
  endfunction
endpackage

// File: rtl/rowout_tick_gen.sv
module rowout_tick_gen
  import rowout_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   run,
  output phase_e phase,
  output logic   pair_end
);
  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_EVEN;
    end else if (start) begin
      phase_q <= PH_EVEN;
    end else if (run) begin
      phase_q <= next_phase(phase_q);
    end else begin
      phase_q <= PH_EVEN;
    end
  end

  assign phase    = phase_q;
  // the internal tick fires once the odd half of a pair is on the output
  assign pair_end = run && (phase_q == PH_ODD);
endmodule

// File: rtl/rowout_pair_counter.sv
module rowout_pair_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pair_end,
  input  logic [CNT_W-1:0] count_in,
  output logic             active,
  output logic             last_pair
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= '0;
      lim_q <= count_in;
    end else if (pair_end) begin
      if (cnt_q == lim_q) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active    = act_q;
  assign last_pair = act_q && (cnt_q == lim_q);
endmodule

// File: rtl/rowout_pair_merge.sv
module rowout_pair_merge
  import rowout_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] even_in,
  input  logic [DATA_W-1:0] odd_in,
  input  phase_e            phase,
  input  logic              enable,
  output logic [DATA_W-1:0] merged
);
  logic [DATA_W-1:0] even_q;
  logic [DATA_W-1:0] odd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (load) begin
      even_q <= even_in;
      odd_q  <= odd_in;
    end
  end

  always_comb begin
    if (!enable)               merged = '0;
    else if (phase == PH_ODD)  merged = odd_q;
    else                       merged = even_q;
  end
endmodule

// File: rtl/dual_pixel_rowout.sv
module dual_pixel_rowout
  import rowout_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_sync,
  input  logic [CNT_W-1:0]  pix_count,
  input  logic [DATA_W-1:0] even_data,
  input  logic [DATA_W-1:0] odd_data,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_valid,
  output logic              end_of_line
);
  phase_e phase;
  logic   pair_end;
  logic   active;
  logic   last_pair;
  logic   load_pair;

  rowout_tick_gen u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (row_sync),
    .run      (active),
    .phase    (phase),
    .pair_end (pair_end)
  );

  rowout_pair_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (row_sync),
    .pair_end  (pair_end),
    .count_in  (pix_count),
    .active    (active),
    .last_pair (last_pair)
  );

  // a new pair is taken at the sync edge or when a non-final pair closes
  assign load_pair = row_sync || (pair_end && !last_pair);

  rowout_pair_merge #(.DATA_W(DATA_W)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_pair),
    .even_in (even_data),
    .odd_in  (odd_data),
    .phase   (phase),
    .enable  (active),
    .merged  (pix_data)
  );

  assign pix_valid   = active;
  assign end_of_line = pair_end && last_pair;
endmodule

// File: rtl/dual_pixel_rowout_chk.sv
module dual_pixel_rowout_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_sync,
  input logic [DATA_W-1:0] pix_data,
  input logic              pix_valid,
  input logic              end_of_line
);
  AST_SYNC_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    row_sync |=> pix_valid); // R1
  AST_ROW_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !end_of_line) |=> pix_valid); // R3
  AST_EOL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    end_of_line |-> pix_valid); // R4
  AST_EOL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_of_line |=> !end_of_line); // R4
  AST_ROW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (end_of_line && !row_sync) |=> !pix_valid); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_data == '0 && !end_of_line)); // R7
endmodule

bind dual_pixel_rowout dual_pixel_rowout_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .row_sync    (row_sync),
  .pix_data    (pix_data),
  .pix_valid   (pix_valid),
  .end_of_line (end_of_line)
);

// File: tb/dual_pixel_rowout_bench.sv
module dual_pixel_rowout_bench;
  localparam int DATA_W = 10;
  localparam int CNT_W  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              row_sync = 1'b0;
  logic [CNT_W-1:0]  pix_count = '0;
  logic [DATA_W-1:0] even_data = '0;
  logic [DATA_W-1:0] odd_data = '0;
  logic [DATA_W-1:0] pix_data;
  logic              pix_valid;
  logic              end_of_line;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string scen = "R3";

  always #10 clk = ~clk; // 50 MHz

  dual_pixel_rowout #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dual_pixel_rowout (
    .clk(clk), .rst_n(rst_n), .row_sync(row_sync), .pix_count(pix_count),
    .even_data(even_data), .odd_data(odd_data), .pix_data(pix_data),
    .pix_valid(pix_valid), .end_of_line(end_of_line)
  );

  // behavioural reference: pixel index within the row and captured pair
  bit m_active = 0;
  bit m_ended  = 0;
  bit m_reset  = 1;
  int m_idx = 0;
  int m_total = 0;
  int m_ev = 0;
  int m_od = 0;

  always @(posedge clk) begin
    cycles++;
    m_ended = 0;
    m_reset = !rst_n;
    if (!rst_n) begin
      m_active = 0; m_idx = 0;
    end else if (row_sync) begin
      m_active = 1; m_idx = 0;
      m_total = 2 * (int'(pix_count) + 1);
      m_ev = int'(even_data); m_od = int'(odd_data);
    end else if (m_active) begin
      m_idx++;
      if (m_idx == m_total) begin
        m_active = 0; m_ended = 1;
      end else if (m_idx % 2 == 0) begin
        m_ev = int'(even_data); m_od = int'(odd_data);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      int exp_d;
      bit exp_e;
      exp_d = !m_active ? 0 : ((m_idx % 2) ? m_od : m_ev);
      exp_e = m_active && (m_idx == m_total - 1);
      if (m_reset) begin
        check(!pix_valid && !end_of_line && pix_data == 0, "R8",
              int'(pix_valid), 0);
      end else begin
        check(pix_valid == m_active, m_ended ? "R5" : scen,
              int'(pix_valid), int'(m_active));
        check(int'(pix_data) == exp_d,
              !m_active ? "R7" : (m_idx == 0 ? "R1" : "R2"),
              int'(pix_data), exp_d);
        check(end_of_line == exp_e, !m_active ? "R7" : "R4",
              int'(end_of_line), int'(exp_e));
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      row_sync  = 1'b0;
      even_data = DATA_W'($urandom);
      odd_data  = DATA_W'($urandom);
    end
  endtask

  task automatic sync(input int n);
    @(negedge clk);
    row_sync  = 1'b1;
    pix_count = CNT_W'(n);
    even_data = DATA_W'($urandom);
    odd_data  = DATA_W'($urandom);
  endtask

  initial begin
    tick(3);
    @(negedge clk) rst_n = 1'b1;
    tick(4);                      // R7 idle
    scen = "R3"; sync(0); tick(5);
    scen = "R10"; sync(3); tick(12);
    scen = "R9"; sync(5);         // R9 count changed mid-row
    @(negedge clk); row_sync = 1'b0; pix_count = CNT_W'(1); tick(16);
    scen = "R6"; sync(7); tick(4); sync(2); tick(3); // R6 restart mid-pair
    sync(4); tick(10);
    sync(1); tick(3); sync(2); tick(8); // R6 sync on the last-pixel edge
    scen = "R3"; sync(100); tick(210);
    sync(2); tick(2);
    @(negedge clk) rst_n = 1'b0;  // R8 reset during a row
    tick(2);
    @(negedge clk) rst_n = 1'b1;
    tick(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=0", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule